// File: doc/BRIEF.md
# Branch Target Address Cache

This block is a small, direct-mapped cache that records where branches sit in the virtual instruction address space. At fetch, the current virtual PC is looked up in the same cycle. On a hit, the block returns the virtual target it has stored and a taken or not-taken guess. The guess comes from a two-bit saturating history held in each entry. When no taken prediction is made, the block gives the sequential address after the fetched instruction, so the front end keeps fetching in a straight line.

Execute reports each resolved branch on an update port: the branch PC, the actual target and whether the branch was taken. A taken branch that is not yet cached is allocated. A branch that is already cached has its history moved one step toward the outcome and its target rewritten.

Because the cache is indexed, tagged and filled with virtual addresses, it must be emptied whenever address mappings change. Three independent sources can request that flush, and any one of them is enough. Prediction is gated by a global flow-prediction enable and by a second enable local to this predictor.

Top module: `bta_cache`

## Requirements
- R1: After reset, every entry is invalid, so no lookup hits until a taken update has been accepted.
- R2: A lookup hits in the same cycle as `fetch_pc` is presented if, and only if, the entry selected by index PC[7:2] is valid, its stored tag equals PC[31:8], and both enables are 1.
- R3: While `flow_en` or `pred_en` is 0, `fetch_hit` and `fetch_taken` are 0, and update requests are ignored, so the contents are unchanged when prediction is enabled again.
- R4: The history counter encodes 00 as strongly not-taken, 01 as weakly not-taken, 10 as weakly taken and 11 as strongly taken. `fetch_taken` is 1 exactly when the lookup hits and bit 1 of the counter is 1.
- R5: When `fetch_taken` is 1, `fetch_target` is the stored target. Otherwise `fetch_target` is `fetch_pc` + 4.
- R6: An accepted update that misses and was taken writes the entry at the clock edge: valid, the tag, the target, and a counter of 10. A lookup sees the new entry from the next cycle. An update that misses and was not taken changes nothing.
- R7: An accepted update that hits rewrites the target and moves the counter one step toward the outcome. The counter saturates at 11 on taken outcomes and at 00 on not-taken outcomes.
- R8: A taken update whose index holds a valid entry with a different tag replaces that entry, and the old branch then misses.
- R9: A 1 on any of `flush_ctrl`, `flush_tlb` or `flush_core` at a clock edge invalidates every entry in that single cycle.
- R10: When a flush and an update arrive in the same cycle, the flush wins and the update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_en | input | 1 | Global program-flow prediction enable |
| pred_en | input | 1 | Enable local to this predictor |
| fetch_pc | input | 32 | Virtual PC looked up at fetch |
| fetch_hit | output | 1 | Lookup found a matching valid entry |
| fetch_taken | output | 1 | Branch predicted taken |
| fetch_target | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Resolved branch reported this cycle |
| upd_pc | input | 32 | Virtual PC of the resolved branch |
| upd_target | input | 32 | Actual virtual target of the branch |
| upd_taken | input | 1 | Branch was taken |
| flush_ctrl | input | 1 | Flush request from the control-register command |
| flush_tlb | input | 1 | Flush request from the main TLB |
| flush_core | input | 1 | Flush request from the integer core |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 6-bit index and 4-byte instructions, which gives 64 entries with 24-bit tags. Random PCs are drawn from four tag values over all 64 indices, so entries are repeatedly aliased and replaced. Random flushes from all three sources and random enable changes are mixed in. Directed runs walk one counter past both saturation ends and make a flush and an update collide in the same cycle.

// File: rtl/bta_cache_pkg.sv
package bta_cache_pkg;

    localparam logic [1:0] CTR_STRONG_NT = 2'b00;
    localparam logic [1:0] CTR_STRONG_T  = 2'b11;
    localparam logic [1:0] CTR_ALLOC     = 2'b10;

    // Saturating step of the two-bit history toward the outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
        if (taken) begin
            return (c == CTR_STRONG_T) ? c : c + 2'd1;
        end
        return (c == CTR_STRONG_NT) ? c : c - 2'd1;
    endfunction

endpackage

// File: rtl/bta_addr_split.sv
module bta_addr_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFS_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
    } split_t;

    split_t split_d;
    logic   unused_ofs;

    always_comb begin
        split_d     = '0;
        split_d.idx = addr[OFS_W +: IDX_W];
        split_d.tag = addr[ADDR_W-1 -: TAG_W];
    end

    assign unused_ofs = ^addr[OFS_W-1:0];
    assign idx        = split_d.idx;
    assign tag        = split_d.tag;
endmodule

// File: rtl/bta_store.sv
module bta_store #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 24,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [IDX_W-1:0]  fa_idx,
    output logic              fa_valid,
    output logic [TAG_W-1:0]  fa_tag,
    output logic [ADDR_W-1:0] fa_target,
    output logic [1:0]        fa_ctr,
    input  logic [IDX_W-1:0]  ua_idx,
    output logic              ua_valid,
    output logic [TAG_W-1:0]  ua_tag,
    output logic [1:0]        ua_ctr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  logic [1:0]        wr_ctr
);
    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][ADDR_W-1:0] target;
        logic [DEPTH-1:0][1:0]        ctr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.valid = '0;
        end else if (wr_en) begin
            st_d.valid[wr_idx]  = 1'b1;
            st_d.tag[wr_idx]    = wr_tag;
            st_d.target[wr_idx] = wr_target;
            st_d.ctr[wr_idx]    = wr_ctr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fa_valid  = st_q.valid[fa_idx];
    assign fa_tag    = st_q.tag[fa_idx];
    assign fa_target = st_q.target[fa_idx];
    assign fa_ctr    = st_q.ctr[fa_idx];
    assign ua_valid  = st_q.valid[ua_idx];
    assign ua_tag    = st_q.tag[ua_idx];
    assign ua_ctr    = st_q.ctr[ua_idx];

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.valid == '0));

    // R6
    write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> st_q.valid[$past(wr_idx)]);
endmodule

// File: rtl/bta_update_ctl.sv
module bta_update_ctl #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 24
) (
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              active,
    input  logic              flush,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [1:0]        ent_ctr,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [ADDR_W-1:0] wr_target,
    output logic [1:0]        wr_ctr
);
    import bta_cache_pkg::*;

    typedef struct packed {
        logic              en;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] target;
        logic [1:0]        ctr;
    } wr_t;

    wr_t  wr_d;
    logic ent_hit;

    assign ent_hit = ent_valid && (ent_tag == upd_tag);

    always_comb begin
        wr_d        = '0;
        wr_d.tag    = upd_tag;
        wr_d.target = upd_target;
        wr_d.en     = upd_valid && active && !flush && (ent_hit || upd_taken);
        wr_d.ctr    = ent_hit ? ctr_step(ent_ctr, upd_taken) : CTR_ALLOC;
    end

    assign wr_en     = wr_d.en;
    assign wr_tag    = wr_d.tag;
    assign wr_target = wr_d.target;
    assign wr_ctr    = wr_d.ctr;
endmodule

// File: rtl/bta_lookup.sv
module bta_lookup #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 24,
    parameter int OFS_W  = 2,
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(1 << OFS_W)
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [TAG_W-1:0]  pc_tag,
    input  logic              active,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [ADDR_W-1:0] ent_target,
    input  logic [1:0]        ent_ctr,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] target
);
    typedef struct packed {
        logic              hit;
        logic              taken;
        logic [ADDR_W-1:0] target;
    } res_t;

    res_t res_d;

    always_comb begin
        res_d        = '0;
        res_d.hit    = active && ent_valid && (ent_tag == pc_tag);
        res_d.taken  = res_d.hit && ent_ctr[1];
        res_d.target = res_d.taken ? ent_target : pc + INSN_BYTES;
    end

    assign hit    = res_d.hit;
    assign taken  = res_d.taken;
    assign target = res_d.target;
endmodule

// File: rtl/bta_cache.sv
module bta_cache #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFS_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_en,
    input  logic              pred_en,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_hit,
    output logic              fetch_taken,
    output logic [ADDR_W-1:0] fetch_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    input  logic              flush_ctrl,
    input  logic              flush_tlb,
    input  logic              flush_core
);
    logic              active, flush;
    logic [IDX_W-1:0]  f_idx, u_idx;
    logic [TAG_W-1:0]  f_tag, u_tag;
    logic              fa_valid, ua_valid;
    logic [TAG_W-1:0]  fa_tag, ua_tag;
    logic [ADDR_W-1:0] fa_target;
    logic [1:0]        fa_ctr, ua_ctr;
    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [ADDR_W-1:0] wr_target;
    logic [1:0]        wr_ctr;

    assign active = flow_en && pred_en;
    assign flush  = flush_ctrl || flush_tlb || flush_core;

    bta_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_fsplit (
        .addr(fetch_pc), .idx(f_idx), .tag(f_tag)
    );

    bta_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_usplit (
        .addr(upd_pc), .idx(u_idx), .tag(u_tag)
    );

    bta_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fa_idx(f_idx), .fa_valid(fa_valid), .fa_tag(fa_tag),
        .fa_target(fa_target), .fa_ctr(fa_ctr),
        .ua_idx(u_idx), .ua_valid(ua_valid), .ua_tag(ua_tag), .ua_ctr(ua_ctr),
        .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(wr_tag),
        .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    bta_update_ctl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_upd (
        .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_tag(u_tag),
        .upd_target(upd_target), .active(active), .flush(flush),
        .ent_valid(ua_valid), .ent_tag(ua_tag), .ent_ctr(ua_ctr),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    bta_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .OFS_W(OFS_W)) u_look (
        .pc(fetch_pc), .pc_tag(f_tag), .active(active),
        .ent_valid(fa_valid), .ent_tag(fa_tag), .ent_target(fa_target),
        .ent_ctr(fa_ctr),
        .hit(fetch_hit), .taken(fetch_taken), .target(fetch_target)
    );

    // R3
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flow_en && pred_en) |-> !fetch_hit);

    // R4
    taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_taken |-> fetch_hit);

    // R5
    fallback_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_taken |-> (fetch_target == fetch_pc + ADDR_W'(1 << OFS_W)));

    // R3
    disabled_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(flow_en && pred_en) && !flush) |=> $stable(u_store.st_q));
endmodule

// File: tb/bta_cache_test.sv
`timescale 1ns/1ps
module bta_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flow_en = 1'b0, pred_en = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_hit, fetch_taken;
    logic [31:0] fetch_target;
    logic        upd_valid = 1'b0, upd_taken = 1'b0;
    logic [31:0] upd_pc = '0, upd_target = '0;
    logic        flush_ctrl = 1'b0, flush_tlb = 1'b0, flush_core = 1'b0;

    int tests = 0;
    int fails = 0;

    // Reference model built from the requirements.
    logic        m_v   [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];
    logic [1:0]  m_ctr [64];

    always #4 clk = ~clk;

    bta_cache uut (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .pred_en(pred_en),
        .fetch_pc(fetch_pc), .fetch_hit(fetch_hit), .fetch_taken(fetch_taken),
        .fetch_target(fetch_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
        .upd_taken(upd_taken),
        .flush_ctrl(flush_ctrl), .flush_tlb(flush_tlb), .flush_core(flush_core)
    );

    function automatic logic [1:0] step(input logic [1:0] c, input logic tk);
        if (tk) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    function automatic logic [33:0] expect_of(input logic [31:0] pc);
        logic [5:0] i;
        logic h, t;
        i = pc[7:2];
        h = flow_en && pred_en && m_v[i] && (m_tag[i] == pc[31:8]);
        t = h && m_ctr[i][1];
        return {h, t, t ? m_tgt[i] : 32'(pc + 32'd4)};
    endfunction

    task automatic check_lookup(input logic [31:0] pc, input string req);
        logic [33:0] e;
        @(negedge clk);
        fetch_pc = pc;
        #1;
        e = expect_of(pc);
        tests++;
        if ({fetch_hit, fetch_taken, fetch_target} !== e) begin
            fails++;
            $display("FAIL %s pc=%h got hit=%b tk=%b tgt=%h exp hit=%b tk=%b tgt=%h",
                     req, pc, fetch_hit, fetch_taken, fetch_target, e[33], e[32], e[31:0]);
        end
    endtask

    task automatic do_cycle(input logic uv, input logic [31:0] pc, input logic [31:0] tg,
                            input logic tk, input logic [2:0] fl);
        logic [5:0] i;
        logic       h;
        @(negedge clk);
        upd_valid = uv; upd_pc = pc; upd_target = tg; upd_taken = tk;
        {flush_ctrl, flush_tlb, flush_core} = fl;
        @(posedge clk);
        i = pc[7:2];
        h = m_v[i] && (m_tag[i] == pc[31:8]);
        if (fl != 3'b000) begin
            for (int k = 0; k < 64; k++) m_v[k] = 1'b0;
        end else if (uv && flow_en && pred_en) begin
            if (h) begin
                m_ctr[i] = step(m_ctr[i], tk);
                m_tgt[i] = tg;
            end else if (tk) begin
                m_v[i] = 1'b1; m_tag[i] = pc[31:8]; m_tgt[i] = tg; m_ctr[i] = 2'b10;
            end
        end
        #1;
        upd_valid = 1'b0;
        {flush_ctrl, flush_tlb, flush_core} = 3'b000;
    endtask

    task automatic upd(input logic [31:0] pc, input logic [31:0] tg, input logic tk);
        do_cycle(1'b1, pc, tg, tk, 3'b000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout exp finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] pa, pb, pc;
        for (int k = 0; k < 64; k++) begin
            m_v[k] = 1'b0; m_tag[k] = '0; m_tgt[k] = '0; m_ctr[k] = '0;
        end
        void'($urandom(32'd1776));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        flow_en = 1'b1; pred_en = 1'b1;

        // R1: empty after reset
        check_lookup(32'h0000_1000, "R1");
        check_lookup(32'hFFFF_FFFC, "R1");

        // R6: taken miss allocates, not-taken miss does not
        pa = 32'h0040_0124;
        upd(pa, 32'h0040_8000, 1'b1);
        check_lookup(pa, "R6 alloc taken");
        pb = 32'h0040_0128;
        upd(pb, 32'h0050_0000, 1'b0);
        check_lookup(pb, "R6 no alloc on not-taken");
        check_lookup(32'h0041_0124, "R2 tag mismatch");

        // R7, R4, R5: counter walk and saturation
        upd(pa, 32'h0040_8000, 1'b0);
        check_lookup(pa, "R4 R5 weak not-taken");
        upd(pa, 32'h0040_8000, 1'b0);
        upd(pa, 32'h0040_8000, 1'b0);
        upd(pa, 32'h0040_8000, 1'b1);
        check_lookup(pa, "R7 saturate at 00");
        upd(pa, 32'h0040_8000, 1'b1);
        upd(pa, 32'h0040_8000, 1'b1);
        upd(pa, 32'h0040_8000, 1'b1);
        upd(pa, 32'h0040_8000, 1'b0);
        check_lookup(pa, "R7 saturate at 11");
        upd(pa, 32'h0060_0040, 1'b1);
        check_lookup(pa, "R7 target rewrite");

        // R8: replacement on aliasing index
        pc = 32'h0777_0124;
        upd(pc, 32'h0000_2000, 1'b1);
        check_lookup(pa, "R8 old evicted");
        check_lookup(pc, "R8 new present");

        // R3: enables
        flow_en = 1'b0;
        check_lookup(pc, "R3 global off");
        flow_en = 1'b1; pred_en = 1'b0;
        check_lookup(pc, "R3 local off");
        upd(32'h0000_3300, 32'h0000_4000, 1'b1);
        pred_en = 1'b1;
        check_lookup(32'h0000_3300, "R3 update ignored");
        check_lookup(pc, "R3 entry retained");

        // R9: each flush source
        for (int s = 0; s < 3; s++) begin
            upd(pa, 32'h0000_5000, 1'b1);
            do_cycle(1'b0, '0, '0, 1'b0, 3'(1 << s));
            check_lookup(pa, "R9 flush source");
            check_lookup(pc, "R9 flush all");
        end

        // R10: flush beats update in same cycle
        do_cycle(1'b1, pa, 32'h0000_6000, 1'b1, 3'b010);
        check_lookup(pa, "R10 flush priority");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] rp;
            int          op;
            rp = {22'h0, 2'($urandom), 6'($urandom), 2'b00};
            op = int'($urandom % 100);
            if (op < 45) begin
                upd(rp, $urandom & 32'hFFFF_FFFC, 1'($urandom));
            end else if (op < 47) begin
                do_cycle(1'($urandom), rp, $urandom, 1'($urandom), 3'(1 << ($urandom % 3)));
            end else if (op < 50) begin
                flow_en = ($urandom % 8) != 0;
                pred_en = ($urandom % 8) != 0;
            end else begin
                check_lookup(rp, "R2 R4 R5 random");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule